// File: doc/BRIEF.md
# Adaptive Write-Invalidate / Write-Update Mode Selector

This block sits beside a coherence directory and decides, for every tracked memory block, whether a write to it should be handled by invalidating the other copies or by pushing the new value to them. Blocks are gathered into groups of consecutive indices. Each group owns one state entry: a mode bit, a write counter, an adaptive update-length counter and a remaining-operations counter. Every block starts in invalidate mode.

The directory reports three kinds of event, each as a strobe with a block index: an invalidation sent because of a write, a cache miss, and an update operation performed. A miss on a block in invalidate mode compares the write counter with a programmable boundary. Few writes since the last miss mean that misses come close together, and the update-length counter steps up. Many writes mean that they are far apart, and it steps down. When the counter reaches a programmable switch value, the group enters update mode for as many update operations as the counter holds, then falls back to invalidate mode. A combinational query port returns the mode of any block index.

Top module: `coh_mode_selector`

## Requirements
- R1: After reset every block reads invalidate mode (qryMode = 0), every update-length counter holds 4 and every write counter holds 0.
- R2: An invalidation strobe adds one to the write counter of the block's group, saturating at its maximum value (255 by default).
- R3: A miss on a group in invalidate mode changes its update-length counter first: it steps down, but not below 1, when the write counter is at least wLimit, and otherwise it steps up, but not above 15. A miss in either mode then clears the write counter.
- R4: If the update-length counter after the R3 step is at least ucSwitch, the group enters update mode (qryMode = 1) and its remaining-operations counter takes the new counter value.
- R5: Each update strobe to a group in update mode lowers the remaining count by one. At zero the group returns to invalidate mode and keeps its update-length counter.
- R6: Update strobes to a group in invalidate mode are ignored. A miss to a group in update mode leaves its mode, update-length counter and remaining count unchanged.
- R7: Blocks whose indices agree above the low GROUP_SHIFT bits (1 by default, so pairs of blocks) share one state entry.
- R8: Strobes of different kinds that hit the same group in one cycle take effect in this order: miss, then invalidation, then update. Each one sees the result of the one before it.
- R9: qryMode is combinational in qryIdx and shows the state left by the most recent clock edge.
- R10: Strobes that hit different groups in the same cycle are each handled in full, and none affects the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wLimit | input | W_WIDTH | Write-count boundary between near and far misses |
| ucSwitch | input | 4 | Counter value that moves a group into update mode |
| invValid | input | 1 | Invalidation sent for invIdx |
| invIdx | input | BLK_IDX_W | Block index of the invalidation |
| missValid | input | 1 | Cache miss on missIdx |
| missIdx | input | BLK_IDX_W | Block index of the miss |
| updValid | input | 1 | Update operation performed on updIdx |
| updIdx | input | BLK_IDX_W | Block index of the update |
| qryIdx | input | BLK_IDX_W | Block index to query |
| qryMode | output | 1 | Mode of qryIdx: 0 invalidate, 1 update |

## Verification
The two functions that can fall in the same cycle are the miss-driven counter step with the mode switch, and the invalidation and update strobes aimed at the same group. The bench fires a miss, an invalidation and an update at one group in a single cycle. The miss must switch the group to update mode, the update must take one operation off the newly loaded remaining count, and the invalidation must leave a write count of one behind, so that a later miss with wLimit = 1 steps the counter down. Each result is judged through the number of further updates needed to leave update mode and through the direction of the next counter step, both compared with an independent model.

// File: rtl/coh_mode_pkg.sv
package coh_mode_pkg;

  localparam int UC_W     = 4;
  localparam int UC_RESET = 4;
  localparam int UC_MAX   = 15;
  localparam int UC_MIN   = 1;

  typedef enum logic {
    MODE_INV = 1'b0,
    MODE_UPD = 1'b1
  } cohMode_t;

  // Per-group strobes from control to datapath
  typedef struct packed {
    logic miss;
    logic inv;
    logic upd;
  } grpStrobe_t;

endpackage

// File: rtl/coh_mode_ctrl.sv
module coh_mode_ctrl
  import coh_mode_pkg::*;
#(
  parameter int BLK_IDX_W   = 4,
  parameter int GROUP_SHIFT = 1,
  localparam int GRP_IDX_W  = BLK_IDX_W - GROUP_SHIFT,
  localparam int NUM_GROUPS = 1 << GRP_IDX_W
) (
  input  logic                             missValid,
  input  logic [BLK_IDX_W-1:0]             missIdx,
  input  logic                             invValid,
  input  logic [BLK_IDX_W-1:0]             invIdx,
  input  logic                             updValid,
  input  logic [BLK_IDX_W-1:0]             updIdx,
  output grpStrobe_t [NUM_GROUPS-1:0]      strbVec
);

  logic [GRP_IDX_W-1:0] missGrp, invGrp, updGrp;

  assign missGrp = missIdx[BLK_IDX_W-1:GROUP_SHIFT];
  assign invGrp  = invIdx[BLK_IDX_W-1:GROUP_SHIFT];
  assign updGrp  = updIdx[BLK_IDX_W-1:GROUP_SHIFT];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gDecode
    assign strbVec[g].miss = missValid && (missGrp == GRP_IDX_W'(g));
    assign strbVec[g].inv  = invValid  && (invGrp  == GRP_IDX_W'(g));
    assign strbVec[g].upd  = updValid  && (updGrp  == GRP_IDX_W'(g));
  end

endmodule

// File: rtl/coh_mode_dp.sv
module coh_mode_dp
  import coh_mode_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int W_WIDTH    = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [W_WIDTH-1:0]          wLimit,
  input  logic [UC_W-1:0]             ucSwitch,
  input  grpStrobe_t [NUM_GROUPS-1:0] strbVec,
  output logic [NUM_GROUPS-1:0]       modeVec
);

  localparam logic [W_WIDTH-1:0] W_MAX   = '1;
  localparam logic [UC_W-1:0]    UC_TOP  = UC_W'(UC_MAX);
  localparam logic [UC_W-1:0]    UC_BOT  = UC_W'(UC_MIN);
  localparam logic [UC_W-1:0]    UC_INIT = UC_W'(UC_RESET);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gEntry
    cohMode_t           modeQ, modeN;
    logic [W_WIDTH-1:0] wQ, wN;
    logic [UC_W-1:0]    ucQ, ucN;
    logic [UC_W-1:0]    remQ, remN;

    always_comb begin
      modeN = modeQ;
      wN    = wQ;
      ucN   = ucQ;
      remN  = remQ;
      // miss first
      if (strbVec[g].miss) begin
        if (modeQ == MODE_INV) begin
          if (wQ >= wLimit) begin
            ucN = (ucQ > UC_BOT) ? ucQ - 1'b1 : ucQ;
          end else begin
            ucN = (ucQ < UC_TOP) ? ucQ + 1'b1 : ucQ;
          end
          if (ucN >= ucSwitch) begin
            modeN = MODE_UPD;
            remN  = ucN;
          end
        end
        wN = '0;
      end
      // then invalidation
      if (strbVec[g].inv && (wN != W_MAX)) begin
        wN = wN + 1'b1;
      end
      // then update
      if (strbVec[g].upd && (modeN == MODE_UPD) && (remN != '0)) begin
        remN = remN - 1'b1;
        if (remN == '0) begin
          modeN = MODE_INV;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        modeQ <= MODE_INV;
        wQ    <= '0;
        ucQ   <= UC_INIT;
        remQ  <= '0;
      end else begin
        modeQ <= modeN;
        wQ    <= wN;
        ucQ   <= ucN;
        remQ  <= remN;
      end
    end

    assign modeVec[g] = (modeQ == MODE_UPD);
  end

endmodule

// File: rtl/coh_mode_selector.sv
module coh_mode_selector
  import coh_mode_pkg::*;
#(
  parameter int BLK_IDX_W   = 4,
  parameter int GROUP_SHIFT = 1,
  parameter int W_WIDTH     = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [W_WIDTH-1:0]   wLimit,
  input  logic [UC_W-1:0]      ucSwitch,
  input  logic                 invValid,
  input  logic [BLK_IDX_W-1:0] invIdx,
  input  logic                 missValid,
  input  logic [BLK_IDX_W-1:0] missIdx,
  input  logic                 updValid,
  input  logic [BLK_IDX_W-1:0] updIdx,
  input  logic [BLK_IDX_W-1:0] qryIdx,
  output logic                 qryMode
);

  localparam int GRP_IDX_W  = BLK_IDX_W - GROUP_SHIFT;
  localparam int NUM_GROUPS = 1 << GRP_IDX_W;

  grpStrobe_t [NUM_GROUPS-1:0] strbVec;
  logic [NUM_GROUPS-1:0]       modeVec;

  coh_mode_ctrl #(
    .BLK_IDX_W  (BLK_IDX_W),
    .GROUP_SHIFT(GROUP_SHIFT)
  ) uCtrl (
    .missValid(missValid),
    .missIdx  (missIdx),
    .invValid (invValid),
    .invIdx   (invIdx),
    .updValid (updValid),
    .updIdx   (updIdx),
    .strbVec  (strbVec)
  );

  coh_mode_dp #(
    .NUM_GROUPS(NUM_GROUPS),
    .W_WIDTH   (W_WIDTH)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .wLimit  (wLimit),
    .ucSwitch(ucSwitch),
    .strbVec (strbVec),
    .modeVec (modeVec)
  );

  assign qryMode = modeVec[qryIdx[BLK_IDX_W-1:GROUP_SHIFT]];

endmodule

// File: rtl/coh_mode_checker.sv
module coh_mode_checker #(
  parameter int BLK_IDX_W   = 4,
  parameter int GROUP_SHIFT = 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [3:0]           ucSwitch,
  input logic                 missValid,
  input logic [BLK_IDX_W-1:0] missIdx,
  input logic                 updValid,
  input logic [BLK_IDX_W-1:0] updIdx,
  input logic [BLK_IDX_W-1:0] qryIdx,
  input logic                 qryMode
);

  logic missHitsQry, updHitsQry;
  assign missHitsQry = missValid &&
    (missIdx[BLK_IDX_W-1:GROUP_SHIFT] == qryIdx[BLK_IDX_W-1:GROUP_SHIFT]);
  assign updHitsQry = updValid &&
    (updIdx[BLK_IDX_W-1:GROUP_SHIFT] == qryIdx[BLK_IDX_W-1:GROUP_SHIFT]);

  AST_RESET_INV: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !qryMode); // R1

  AST_INV_NEEDS_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (!qryMode && !missHitsQry) |=> ($stable(qryIdx) -> !qryMode)); // R6

  AST_UPD_NEEDS_UPDOP: assert property (@(posedge clk) disable iff (!rstN)
    (qryMode && !updHitsQry) |=> ($stable(qryIdx) -> qryMode)); // R5

  AST_SWITCH_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!qryMode && missHitsQry && !updHitsQry && ucSwitch == 4'd0)
      |=> ($stable(qryIdx) -> qryMode)); // R4

  AST_QRY_KNOWN: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown(qryMode)); // R9

endmodule

bind coh_mode_selector coh_mode_checker #(
  .BLK_IDX_W  (BLK_IDX_W),
  .GROUP_SHIFT(GROUP_SHIFT)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .ucSwitch (ucSwitch),
  .missValid(missValid),
  .missIdx  (missIdx),
  .updValid (updValid),
  .updIdx   (updIdx),
  .qryIdx   (qryIdx),
  .qryMode  (qryMode)
);

// File: tb/sim_coh_mode_selector.sv
module sim_coh_mode_selector;

  localparam int NB = 16;
  localparam int NG = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] wLimit = 8'd3;
  logic [3:0] ucSwitch = 4'd6;
  logic       invValid = 1'b0, missValid = 1'b0, updValid = 1'b0;
  logic [3:0] invIdx = '0, missIdx = '0, updIdx = '0, qryIdx = '0;
  logic       qryMode;

  always #5 clk = ~clk;

  coh_mode_selector u0 (
    .clk(clk), .rstN(rstN), .wLimit(wLimit), .ucSwitch(ucSwitch),
    .invValid(invValid), .invIdx(invIdx),
    .missValid(missValid), .missIdx(missIdx),
    .updValid(updValid), .updIdx(updIdx),
    .qryIdx(qryIdx), .qryMode(qryMode)
  );

  // reference model
  int mMode[NG], mW[NG], mUc[NG], mRem[NG];

  typedef struct {
    int    idx;
    bit    exp;
    string tag;
  } item_t;

  item_t scb[$];
  event  chkEv;
  int    nVec = 0, nBad = 0;
  bit    done = 0;

  // monitor: pops expected items and compares
  initial begin
    forever begin
      @(chkEv);
      #1;
      begin
        item_t it;
        it = scb.pop_front();
        nVec++;
        if (qryMode !== it.exp) begin
          nBad++;
          $display("FAIL %s block %0d: qryMode=%0b expected=%0b", it.tag, it.idx, qryMode, it.exp);
        end
      end
    end
  end

  task automatic check(input int idx, input string tag);
    item_t it;
    qryIdx = 4'(idx);
    it.idx = idx; it.exp = mMode[idx >> 1][0]; it.tag = tag;
    scb.push_back(it);
    ->chkEv;
    #2;
  endtask

  task automatic modelEdge(input bit mv, input int mi, input bit iv, input int ii,
                           input bit uv, input int ui);
    for (int g = 0; g < NG; g++) begin
      if (mv && (mi >> 1) == g) begin
        if (mMode[g] == 0) begin
          if (mW[g] >= int'(wLimit)) mUc[g] = (mUc[g] > 1) ? mUc[g] - 1 : 1;
          else                       mUc[g] = (mUc[g] < 15) ? mUc[g] + 1 : 15;
          if (mUc[g] >= int'(ucSwitch)) begin
            mMode[g] = 1;
            mRem[g]  = mUc[g];
          end
        end
        mW[g] = 0;
      end
      if (iv && (ii >> 1) == g) mW[g] = (mW[g] < 255) ? mW[g] + 1 : 255;
      if (uv && (ui >> 1) == g && mMode[g] == 1) begin
        mRem[g]--;
        if (mRem[g] == 0) mMode[g] = 0;
      end
    end
  endtask

  task automatic step(input bit mv, input int mi, input bit iv, input int ii,
                      input bit uv, input int ui);
    @(negedge clk);
    missValid = mv; missIdx = 4'(mi);
    invValid  = iv; invIdx  = 4'(ii);
    updValid  = uv; updIdx  = 4'(ui);
    @(posedge clk);
    modelEdge(mv, mi, iv, ii, uv, ui);
    @(negedge clk);
    missValid = 0; invValid = 0; updValid = 0;
  endtask

  task automatic miss(input int b);  step(1, b, 0, 0, 0, 0); endtask
  task automatic inval(input int b); step(0, 0, 1, b, 0, 0); endtask
  task automatic upd(input int b);   step(0, 0, 0, 0, 1, b); endtask

  initial begin
    for (int g = 0; g < NG; g++) begin
      mMode[g] = 0; mW[g] = 0; mUc[g] = 4; mRem[g] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 / R9: reset state on every block
    for (int b = 0; b < NB; b++) check(b, "R1");

    // R3 / R4: close misses step up, switch at ucSwitch=6
    wLimit = 3; ucSwitch = 6;
    miss(0); check(0, "R3");
    miss(0); check(0, "R4"); check(1, "R7");
    // R5: six updates, the last returns to invalidate
    for (int k = 0; k < 5; k++) upd(1);
    check(0, "R5");
    upd(1); check(1, "R5");
    // R6: update on an invalidate-mode group ignored
    upd(0); check(0, "R6");
    upd(1); check(1, "R6");

    // R2 / R3: far miss steps down, so two close misses do not switch
    for (int k = 0; k < 3; k++) inval(4);
    miss(4); check(4, "R2");
    miss(4); miss(4); check(5, "R3");
    miss(4); check(4, "R4");
    for (int k = 0; k < 6; k++) upd(5);
    check(4, "R5");

    // R8: miss + invalidation + update to one group in one cycle
    ucSwitch = 5;
    step(1, 6, 1, 7, 1, 6); check(6, "R8");
    for (int k = 0; k < 3; k++) upd(7);
    check(7, "R8");
    upd(6); check(6, "R8");
    wLimit = 1;
    miss(6); check(6, "R8");
    miss(7); check(6, "R8");
    for (int k = 0; k < 5; k++) upd(6);
    check(6, "R8");

    // R10: different groups in one cycle
    wLimit = 3; ucSwitch = 5;
    step(1, 8, 1, 10, 1, 12);
    check(8, "R10"); check(10, "R10"); check(12, "R10");
    for (int k = 0; k < 5; k++) upd(9);
    check(8, "R10");

    // R3 upper saturation on group 6
    wLimit = 8'd255; ucSwitch = 15;
    for (int k = 0; k < 10; k++) miss(12);
    check(12, "R3");
    miss(13); check(12, "R4");
    for (int k = 0; k < 14; k++) upd(12);
    check(13, "R5");
    upd(12); check(12, "R5");
    miss(12); check(12, "R3");
    // R6: miss in update mode keeps mode and remaining count
    miss(12); check(12, "R6");
    for (int k = 0; k < 14; k++) upd(13);
    check(12, "R6");
    upd(13); check(12, "R6");

    // R3 lower saturation on group 7
    wLimit = 0; ucSwitch = 15;
    for (int k = 0; k < 5; k++) miss(14);
    ucSwitch = 2;
    miss(14); check(14, "R3");
    ucSwitch = 1;
    miss(15); check(14, "R4");
    upd(14); check(15, "R5");

    // mixed traffic against the model
    for (int n = 0; n < 1500; n++) begin
      if (n % 50 == 0) begin
        wLimit   = 8'($urandom_range(0, 4));
        ucSwitch = 4'($urandom_range(2, 9));
      end
      step($urandom_range(0, 2) == 0, int'($urandom_range(0, NB - 1)),
           $urandom_range(0, 1) == 0, int'($urandom_range(0, NB - 1)),
           $urandom_range(0, 1) == 0, int'($urandom_range(0, NB - 1)));
      check(int'($urandom_range(0, NB - 1)), "R10");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nVec++; nBad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

endmodule